// File: doc/BRIEF.md
# Card Bus Clock Generator with Power-Up Burst

This block produces the clock that drives a memory-card bus from the master clock of the chip. A mode word sets an 8-bit divide value N, and the card clock runs at the master rate divided by 2×(N+1). The clock is therefore always a whole number of master cycles high and the same number low. A control word turns the interface on and off and can return every setting to its default. A mode word also selects two flow-control stalls. These stalls park the card clock low while the receive holding register is full and unread, or while the transmit holding register is empty.

Writing a command word whose special-command field asks for card initialization starts a burst of 74 card clock cycles. During the burst the command-ready flag is low. The flag returns high on the falling card-clock edge that ends the 74th cycle. Command shifting, CRC, response capture and the data path sit in neighbouring blocks. They take the card clock and the ready flag from here and report the holding-register levels back.

Top module: `card_clk_gen`

## Requirements
- R1: With divide value N in mode word (select 1) bits 7:0, the running card clock has a period of 2×(N+1) master cycles, with high and low phases of N+1 cycles each.
- R2: N=0 gives a period of 2 master cycles and N=255 gives a period of 512.
- R3: A control word (select 0) with bit 0 set enables the interface and with bit 1 set disables it; when both are set, disable wins. `ifEnabled` shows the current state.
- R4: While the interface is disabled the card clock is low.
- R5: A control word with bit 7 set restores all defaults: the interface is disabled, N=0, both stalls are off, any burst is dropped and `cmdReady` is high. Bit 7 takes priority over bits 0 and 1.
- R6: A command word (select 2) with bits 10:8 equal to 1 drops `cmdReady` on the next cycle. It then produces exactly 74 rising card-clock edges, and `cmdReady` rises with the falling edge after the 74th.
- R7: Command words with any other value in bits 10:8 leave `cmdReady` unchanged. An initialization command written while a burst is running is ignored and does not extend the burst.
- R8: With mode bit 11 set, the card clock holds low while `rxFull` is high and resumes its normal period once `rxFull` drops. With bit 11 clear, `rxFull` has no effect.
- R9: With mode bit 12 set, the card clock holds low while `txEmpty` is high and resumes once it drops. With bit 12 clear, `txEmpty` has no effect.
- R10: A new divide value takes effect only at a clock toggle. Every high or low phase is therefore exactly old N+1 or new N+1 cycles long, and no shortened pulse appears.
- R11: After the reset input the card clock is low, the interface is disabled and `cmdReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 control, 1 mode, 2 command, 3 unused |
| wrData | input | 32 | Write data |
| rxFull | input | 1 | Receive holding register full and unread |
| txEmpty | input | 1 | Transmit holding register empty |
| cardClk | output | 1 | Card bus clock |
| cmdReady | output | 1 | Command-ready flag |
| ifEnabled | output | 1 | Interface enabled |

## Verification
The period is measured for the two extreme divide values and for a seeded random spread of small values. This separates an off-by-one in the terminal count from a wrong factor of two. Phase lengths are logged across a divide change made mid-phase, so a runt or an early switch shows up as an unexpected length. The initialization burst is counted edge by edge in three cases: on its own, with a second initialization command written part-way through, and with a non-initialization command. These cases separate a correct count from a restart or an unwanted flag clear. Each stall is applied with its mode bit on and with it off, which shows that the stall is gated by its mode bit.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  parameter int DIV_W       = 8;
  parameter int DATA_W      = 32;
  parameter int INIT_CYCLES = 74;
  localparam int RISE_W     = $clog2(INIT_CYCLES + 1);

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;

  localparam int CTRL_ON_BIT   = 0;
  localparam int CTRL_OFF_BIT  = 1;
  localparam int CTRL_RST_BIT  = 7;
  localparam int MODE_RDP_BIT  = 11;
  localparam int MODE_WRP_BIT  = 12;
  localparam int CMD_SPC_LO    = 8;
  localparam logic [2:0] SPC_INIT = 3'd1;

  typedef struct packed {
    logic             run;
    logic             stall;
    logic [DIV_W-1:0] div;
  } clkCtl_t;

  typedef struct packed {
    logic rise;
    logic fall;
  } clkEvt_t;
endpackage

// File: rtl/card_clk_ctrl.sv
module card_clk_ctrl
  import card_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxFull,
  input  logic              txEmpty,
  input  clkEvt_t           evt,
  output clkCtl_t           ctl,
  output logic              cmdReady,
  output logic              ifEnabled,
  output logic              rdProofOn,
  output logic              wrProofOn
);
  logic [DIV_W-1:0]  divReg;
  logic [RISE_W-1:0] risesLeft;
  logic              burstBusy;
  logic              ctrlWr, modeWr, initWr;

  assign ctrlWr = wrEn && (wrSel == SEL_CTRL);
  assign modeWr = wrEn && (wrSel == SEL_MODE);
  assign initWr = wrEn && (wrSel == SEL_CMD) &&
                  (wrData[CMD_SPC_LO +: 3] == SPC_INIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ifEnabled <= 1'b0;
      divReg    <= '0;
      rdProofOn <= 1'b0;
      wrProofOn <= 1'b0;
      cmdReady  <= 1'b1;
      burstBusy <= 1'b0;
      risesLeft <= '0;
    end else if (ctrlWr && wrData[CTRL_RST_BIT]) begin
      ifEnabled <= 1'b0;
      divReg    <= '0;
      rdProofOn <= 1'b0;
      wrProofOn <= 1'b0;
      cmdReady  <= 1'b1;
      burstBusy <= 1'b0;
      risesLeft <= '0;
    end else begin
      if (ctrlWr) begin
        if (wrData[CTRL_OFF_BIT])     ifEnabled <= 1'b0;
        else if (wrData[CTRL_ON_BIT]) ifEnabled <= 1'b1;
      end
      if (modeWr) begin
        divReg    <= wrData[DIV_W-1:0];
        rdProofOn <= wrData[MODE_RDP_BIT];
        wrProofOn <= wrData[MODE_WRP_BIT];
      end
      if (initWr && !burstBusy) begin
        burstBusy <= 1'b1;
        cmdReady  <= 1'b0;
        risesLeft <= RISE_W'(INIT_CYCLES);
      end else if (burstBusy) begin
        if (evt.rise && risesLeft != '0)
          risesLeft <= risesLeft - 1'b1;
        if (evt.fall && risesLeft == '0) begin
          burstBusy <= 1'b0;
          cmdReady  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.run   = ifEnabled;
    ctl.stall = (rdProofOn && rxFull) || (wrProofOn && txEmpty);
    ctl.div   = divReg;
  end
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import card_clk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  clkCtl_t ctl,
  output clkEvt_t evt,
  output logic    cardClk
);
  logic [DIV_W-1:0] phaseCnt;
  logic [DIV_W-1:0] activeDiv;
  logic             parked;
  logic             toggle;

  assign parked = !cardClk && ctl.stall;
  assign toggle = ctl.run && !parked && (phaseCnt == activeDiv);

  always_comb begin
    evt.rise = toggle && !cardClk;
    evt.fall = toggle && cardClk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt  <= '0;
      activeDiv <= '0;
      cardClk   <= 1'b0;
    end else if (!ctl.run) begin
      phaseCnt  <= '0;
      activeDiv <= ctl.div;
      cardClk   <= 1'b0;
    end else if (parked) begin
      phaseCnt  <= phaseCnt;
    end else if (toggle) begin
      phaseCnt  <= '0;
      activeDiv <= ctl.div;
      cardClk   <= !cardClk;
    end else begin
      phaseCnt  <= phaseCnt + 1'b1;
    end
  end
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import card_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxFull,
  input  logic              txEmpty,
  output logic              cardClk,
  output logic              cmdReady,
  output logic              ifEnabled
);
  clkCtl_t ctlBus;
  clkEvt_t evtBus;
  logic    rdProofOn, wrProofOn;

  card_clk_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rxFull(rxFull), .txEmpty(txEmpty), .evt(evtBus), .ctl(ctlBus),
    .cmdReady(cmdReady), .ifEnabled(ifEnabled),
    .rdProofOn(rdProofOn), .wrProofOn(wrProofOn)
  );

  card_clk_div i_div (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .evt(evtBus), .cardClk(cardClk)
  );
endmodule

// File: rtl/card_clk_chk.sv
module card_clk_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrSel,
  input logic       rxFull,
  input logic       txEmpty,
  input logic       cardClk,
  input logic       cmdReady,
  input logic       ifEnabled,
  input logic       rdProofOn,
  input logic       wrProofOn
);
  assert_off_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ifEnabled |=> !cardClk);

  assert_rise_needs_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardClk) |-> $past(ifEnabled));

  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!cardClk && rdProofOn && rxFull) |=> !cardClk);

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!cardClk && wrProofOn && txEmpty) |=> !cardClk);

  assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdReady) |-> $past(wrEn && wrSel == 2'd2));

  assert_ready_on_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cmdReady) && ifEnabled) |-> $fell(cardClk));
endmodule

bind card_clk_gen card_clk_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .rxFull(rxFull),
  .txEmpty(txEmpty), .cardClk(cardClk), .cmdReady(cmdReady),
  .ifEnabled(ifEnabled), .rdProofOn(rdProofOn), .wrProofOn(wrProofOn)
);

// File: tb/test_card_clk_gen.sv
module test_card_clk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = '0;
  logic        rxFull = 1'b0;
  logic        txEmpty = 1'b0;
  logic        cardClk, cmdReady, ifEnabled;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  card_clk_gen i_card_clk_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rxFull(rxFull), .txEmpty(txEmpty), .cardClk(cardClk),
    .cmdReady(cmdReady), .ifEnabled(ifEnabled)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  function automatic int expPeriod(int n);
    return 2 * (n + 1);
  endfunction

  function automatic logic [31:0] modeWord(int n, bit rdp, bit wrp);
    return (32'(n) & 32'hFF) | (32'(rdp) << 11) | (32'(wrp) << 12);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic measurePeriod(output int p);
    int guard = 0;
    p = -1;
    while (cardClk !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
    while (cardClk !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    p = 0;
    while (cardClk !== 1'b0 && guard < 2000) begin @(negedge clk); p++; guard++; end
    while (cardClk !== 1'b1 && guard < 2000) begin @(negedge clk); p++; guard++; end
    if (guard >= 2000) p = -1;
  endtask

  task automatic burstRises(input int extraAt, output int rises);
    logic prev;
    int guard = 0;
    rises = 0;
    prev = cardClk;
    while (cmdReady !== 1'b1 && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (prev === 1'b0 && cardClk === 1'b1) begin
        rises++;
        if (rises == extraAt) begin
          wrEn = 1'b1; wrSel = 2'd2; wrData = 32'h0000_0100;
          @(negedge clk);
          wrEn = 1'b0; wrData = '0;
          guard++;
        end
      end
      prev = cardClk;
    end
  endtask

  initial begin : watchdog
    while (!done && cycles < WATCHDOG) begin @(posedge clk); cycles++; end
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    int p, seed, n, rises, highs, len, cur;
    bit okPh;
    seed = $urandom(32'd5173);

    repeat (3) @(negedge clk);
    check(cardClk === 1'b0, "R11 clock low in reset", int'(cardClk), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady === 1'b1, "R11 ready after reset", int'(cmdReady), 1);
    check(ifEnabled === 1'b0, "R11 disabled after reset", int'(ifEnabled), 0);

    repeat (50) @(negedge clk);
    check(cardClk === 1'b0, "R4 low while disabled", int'(cardClk), 0);

    writeReg(2'd0, 32'h1);
    check(ifEnabled === 1'b1, "R3 enable bit", int'(ifEnabled), 1);

    measurePeriod(p);
    check(p == expPeriod(0), "R2 period N=0", p, expPeriod(0));
    writeReg(2'd1, modeWord(255, 0, 0));
    measurePeriod(p);
    measurePeriod(p);
    check(p == expPeriod(255), "R2 period N=255", p, expPeriod(255));

    for (int i = 0; i < 6; i++) begin
      n = int'($urandom % 16);
      writeReg(2'd1, modeWord(n, 0, 0));
      measurePeriod(p);
      measurePeriod(p);
      check(p == expPeriod(n), "R1 random period", p, expPeriod(n));
    end

    writeReg(2'd1, modeWord(3, 0, 0));
    measurePeriod(p);
    repeat (2) @(negedge clk);
    writeReg(2'd1, modeWord(9, 0, 0));
    cur = int'(cardClk);
    while (int'(cardClk) == cur) @(negedge clk);
    okPh = 1'b1;
    for (int k = 0; k < 6; k++) begin
      cur = int'(cardClk); len = 0;
      while (int'(cardClk) == cur && len < 100) begin @(negedge clk); len++; end
      if (len != 4 && len != 10) okPh = 1'b0;
      check(len == 4 || len == 10, "R10 phase length", len, 10);
    end
    measurePeriod(p);
    check(p == expPeriod(9), "R10 new period", p, expPeriod(9));

    writeReg(2'd1, modeWord(1, 0, 0));
    writeReg(2'd2, 32'h0000_0100);
    check(cmdReady === 1'b0, "R6 ready drops", int'(cmdReady), 0);
    burstRises(0, rises);
    check(rises == 74, "R6 burst length", rises, 74);
    check(cardClk === 1'b0, "R6 ready at falling edge", int'(cardClk), 0);

    writeReg(2'd2, 32'h0000_0200);
    check(cmdReady === 1'b1, "R7 other command keeps ready", int'(cmdReady), 1);
    writeReg(2'd2, 32'h0000_0000);
    check(cmdReady === 1'b1, "R7 plain command keeps ready", int'(cmdReady), 1);

    writeReg(2'd2, 32'h0000_0100);
    burstRises(10, rises);
    check(rises == 74, "R7 second init ignored", rises, 74);

    writeReg(2'd1, modeWord(2, 1, 0));
    rxFull = 1'b1;
    repeat (20) @(negedge clk);
    highs = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); if (cardClk) highs++; end
    check(highs == 0, "R8 read stall holds low", highs, 0);
    rxFull = 1'b0;
    measurePeriod(p);
    check(p == expPeriod(2), "R8 resume after read", p, expPeriod(2));
    writeReg(2'd1, modeWord(2, 0, 0));
    rxFull = 1'b1;
    measurePeriod(p);
    check(p == expPeriod(2), "R8 no stall when off", p, expPeriod(2));
    rxFull = 1'b0;

    writeReg(2'd1, modeWord(2, 0, 1));
    txEmpty = 1'b1;
    repeat (20) @(negedge clk);
    highs = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); if (cardClk) highs++; end
    check(highs == 0, "R9 write stall holds low", highs, 0);
    txEmpty = 1'b0;
    measurePeriod(p);
    check(p == expPeriod(2), "R9 resume after write", p, expPeriod(2));
    writeReg(2'd1, modeWord(2, 0, 0));
    txEmpty = 1'b1;
    measurePeriod(p);
    check(p == expPeriod(2), "R9 no stall when off", p, expPeriod(2));
    txEmpty = 1'b0;

    writeReg(2'd1, modeWord(5, 1, 1));
    writeReg(2'd2, 32'h0000_0100);
    repeat (30) @(negedge clk);
    writeReg(2'd0, 32'h81);
    check(ifEnabled === 1'b0, "R5 reset disables", int'(ifEnabled), 0);
    check(cmdReady === 1'b1, "R5 reset restores ready", int'(cmdReady), 1);
    repeat (5) @(negedge clk);
    check(cardClk === 1'b0, "R4 low after reset", int'(cardClk), 0);
    rxFull = 1'b1; txEmpty = 1'b1;
    writeReg(2'd0, 32'h1);
    measurePeriod(p);
    check(p == expPeriod(0), "R5 divide and stalls cleared", p, expPeriod(0));
    rxFull = 1'b0; txEmpty = 1'b0;

    writeReg(2'd0, 32'h3);
    check(ifEnabled === 1'b0, "R3 disable wins", int'(ifEnabled), 0);
    repeat (3) @(negedge clk);
    check(cardClk === 1'b0, "R4 low after disable", int'(cardClk), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule